// File: doc/BRIEF.md
# Serial Receiver with Break Detection and Per-Character Error Status

This block receives asynchronous serial characters on one data line. The line is sampled at sixteen times the bit rate. Each character can be five to eight bits long and may carry an optional parity bit. Every completed character goes into an eight-deep receive queue, together with three flags kept for that character: break, framing error and parity error. The host reads the head of the queue through a data port and an eight-bit status word. It removes the head with a one-cycle read strobe.

A break is a received character whose data bits, parity bit (if present) and stop sample are all zero. A break produces exactly one queue entry. After that, the receiver writes nothing more until the line has stayed at mark for half a bit time. A change-of-break flag rises when a break is detected and again when it ends. The host clears this flag, the sticky overrun flag and the queue with short command codes. Two transmitter indications enter as inputs and are placed unchanged into the status word.

Top module: `serial_rx_status`

## Requirements
- R1: The line is sampled on each `baud_tick`, at 16 ticks per bit. A falling edge counts as a start bit only if the line is still low on the 8th tick after it. Otherwise the edge is ignored and nothing is stored. Data bits arrive LSB first and are sampled every 16 ticks after the middle of the start bit. `char_len` selects the length: 00 is 5 bits, 01 is 6, 10 is 7 and 11 is 8. Unused upper bits of `rx_data` read 0.
- R2: The stop bit is sampled once, at its middle. If that sample is low and the character is not a break, the character is stored with its framing flag set.
- R3: `parity_mode` selects how the bit after the data is handled. With 00 there is no parity bit. With 01 the parity is checked: `parity_sel` 0 means even and 1 means odd, and the flag is set on a mismatch. With 10 the parity bit is forced: the flag is set if the received bit differs from `parity_sel`. With 11 the received bit is an address/data marker and is stored as-is in the parity flag position.
- R4: A break is stored as one entry with data 0, the break flag set, and the framing and parity flags clear.
- R5: After a break, no entry is written until `rxd` has been high for 8 consecutive ticks. A low sample during that wait restarts the count.
- R6: `break_chg` is set when a break is detected and set again when its end is detected. Command code 5'b00101 clears it. If a set and a clear arrive in the same cycle, the set wins.
- R7: A break that begins partway through a character stores that character with its framing flag set. If the line is still low through the end of the following character, the break is stored as the next entry.
- R8: The queue holds 8 entries. `status[0]` is 1 when the queue is not empty and `status[1]` is 1 when it is full. A `rd_pop` pulse removes the head entry. A `rd_pop` pulse on an empty queue has no effect.
- R9: A character that completes while the queue is full, with no read in the same cycle, is dropped. It sets `status[4]`, which stays at 1 until command code 5'b00100.
- R10: In the status word, bits 7, 6 and 5 are the break, framing and parity flags of the head entry (all 0 when the queue is empty). Bit 4 is overrun, bit 3 is `tx_empty` and bit 2 is `tx_ready`.
- R11: Command code 5'b00010 empties the queue. Any code not named in R6, R9 or R11 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_tick | input | 1 | Enable pulse at 16 times the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| char_len | input | 2 | Character length select |
| parity_mode | input | 2 | Parity handling select |
| parity_sel | input | 1 | Odd/even select, or the forced parity value |
| rd_pop | input | 1 | Remove the head entry from the queue |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 5 | Command code |
| tx_empty | input | 1 | Transmitter-empty indication, passed to status[3] |
| tx_ready | input | 1 | Transmitter-ready indication, passed to status[2] |
| status | output | 8 | Status word |
| rx_data | output | 8 | Data of the head entry |
| break_chg | output | 1 | Change-of-break flag |

## Verification
The bench holds the line low for many character times and checks that exactly one break entry appears. A receiver that kept re-framing during the break would fill the queue with zero characters. It sends a brief high pulse during the break and checks that the change-of-break flag stays clear until the line has been high for a full half bit. A design that ended the break on the first high sample would raise the flag too early. It starts a break in the middle of a character and expects two entries: the damaged character with a framing error, then the break. It also fills the queue past full and checks that the head is kept, the extra character is dropped, and overrun stays set until its own clear command.

// File: rtl/uart_rx_pkg.sv
// Shared types and command codes for the serial receiver.
package uart_rx_pkg;

    localparam int RX_DATA_W = 8;

    // Handling of the bit that follows the data bits.
    typedef enum logic [1:0] {
        PAR_NONE  = 2'b00,
        PAR_CHECK = 2'b01,
        PAR_FORCE = 2'b10,
        PAR_ADDR  = 2'b11
    } par_mode_e;

    // Host command codes.
    localparam logic [4:0] CMD_FLUSH_RX   = 5'b00010;
    localparam logic [4:0] CMD_CLR_ERR    = 5'b00100;
    localparam logic [4:0] CMD_CLR_BRKCHG = 5'b00101;

    // One queue entry: per-character flags plus data.
    typedef struct packed {
        logic                 brk;
        logic                 fe;
        logic                 pe;
        logic [RX_DATA_W-1:0] data;
    } rx_entry_t;

endpackage

// File: rtl/rx_frame_engine.sv
// Character framer. Qualifies the start bit at mid-bit, shifts in 5..8
// data bits LSB first, takes an optional parity bit and samples the stop
// bit at its middle. When a character completes, it emits a one-cycle
// pulse with the data and flags. After a break it holds off until the line
// has been high for half a bit, then pulses brk_end_o.
// Assumes: baud_tick_i pulses OVS times per bit; configuration is stable
// while a character is in flight.
module rx_frame_engine
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    input  logic      rxd_i,
    input  logic [1:0] len_sel_i,
    input  par_mode_e par_mode_i,
    input  logic      par_sel_i,
    output logic      char_done_o,
    output rx_entry_t char_o,
    output logic      brk_end_o
);

    localparam int PH_W = $clog2(OVS + 1);
    localparam int HALF = OVS / 2;
    localparam int HI_W = $clog2(HALF + 1);
    localparam logic [PH_W-1:0] PH_MID  = PH_W'(OVS / 2 - 1);
    localparam logic [PH_W-1:0] PH_FULL = PH_W'(OVS);
    localparam logic [HI_W-1:0] HI_LAST = HI_W'(HALF - 1);

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRKW
    } fr_state_e;

    fr_state_e            state;
    logic [PH_W-1:0]      phase;
    logic [2:0]           bit_idx;
    logic [RX_DATA_W-1:0] shift_q;
    logic                 par_q;
    logic [HI_W-1:0]      hi_cnt;

    logic      par_on;
    logic [2:0] last_idx;
    logic      brk_now;
    logic      pe_raw;
    rx_entry_t frame_w;

    // Decode the configuration and build the entry presented at the stop sample.
    always_comb begin
        par_on   = (par_mode_i != PAR_NONE);
        last_idx = 3'd4 + {1'b0, len_sel_i};
        brk_now  = (shift_q == '0) && (!par_on || !par_q) && !rxd_i;
        case (par_mode_i)
            PAR_CHECK: pe_raw = (^shift_q) ^ par_q ^ par_sel_i;
            PAR_FORCE: pe_raw = par_q ^ par_sel_i;
            PAR_ADDR:  pe_raw = par_q;
            default:   pe_raw = 1'b0;
        endcase
        frame_w.brk  = brk_now;
        frame_w.fe   = !rxd_i && !brk_now;
        frame_w.pe   = brk_now ? 1'b0 : pe_raw;
        frame_w.data = shift_q;
    end

    // Framing state machine, advanced on each oversampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            phase       <= '0;
            bit_idx     <= '0;
            shift_q     <= '0;
            par_q       <= 1'b0;
            hi_cnt      <= '0;
            char_done_o <= 1'b0;
            char_o      <= '0;
            brk_end_o   <= 1'b0;
        end else begin
            char_done_o <= 1'b0;
            brk_end_o   <= 1'b0;
            if (tick_i) begin
                case (state)
                    ST_IDLE: begin
                        if (!rxd_i) begin
                            state <= ST_START;
                            phase <= PH_W'(1);
                        end
                    end
                    ST_START: begin
                        if (phase == PH_MID) begin
                            if (!rxd_i) begin
                                state   <= ST_DATA;
                                phase   <= PH_W'(1);
                                bit_idx <= '0;
                                shift_q <= '0;
                                par_q   <= 1'b0;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (phase == PH_FULL) begin
                            phase            <= PH_W'(1);
                            shift_q[bit_idx] <= rxd_i;
                            if (bit_idx == last_idx) begin
                                state <= par_on ? ST_PAR : ST_STOP;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (phase == PH_FULL) begin
                            phase <= PH_W'(1);
                            par_q <= rxd_i;
                            state <= ST_STOP;
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (phase == PH_FULL) begin
                            char_done_o <= 1'b1;
                            char_o      <= frame_w;
                            if (brk_now) begin
                                state  <= ST_BRKW;
                                hi_cnt <= '0;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                    ST_BRKW: begin
                        if (rxd_i) begin
                            if (hi_cnt == HI_LAST) begin
                                brk_end_o <= 1'b1;
                                state     <= ST_IDLE;
                            end else begin
                                hi_cnt <= hi_cnt + 1'b1;
                            end
                        end else begin
                            hi_cnt <= '0;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R5: no character is emitted while still waiting for the line to recover.
    p_one_entry_per_break_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BRKW && $past(state == ST_BRKW)) |-> !char_done_o);

    // R1: each completed character is announced for exactly one cycle.
    p_done_single_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        char_done_o |=> !char_done_o);

    // R4: a break entry carries zero data and no other flag.
    p_break_entry_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done_o && char_o.brk) |-> (char_o.data == '0 && !char_o.fe && !char_o.pe));

endmodule

// File: rtl/rx_flag_fifo.sv
// Receive queue of character entries with their flags. Presents the head
// entry combinationally. A pop on an empty queue is ignored. A push is
// taken when there is room or when a pop in the same cycle makes room.
// Flush has priority over both.
// Assumes: the producer never pushes into a full queue without a pop.
module rx_flag_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      flush_i,
    input  logic      push_i,
    input  rx_entry_t entry_i,
    input  logic      pop_i,
    output rx_entry_t head_o,
    output logic      empty_o,
    output logic      full_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    rx_entry_t       mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic [CW-1:0]   count;
    logic            pop_ok;
    logic            push_ok;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Qualify the requests against occupancy.
    always_comb begin
        empty_o = (count == '0);
        full_o  = (count == CW'(DEPTH));
        pop_ok  = pop_i && !empty_o;
        push_ok = push_i && (!full_o || pop_ok);
        head_o  = mem[rd_ptr];
    end

    // Entry storage; contents need no reset because the count gates them.
    always_ff @(posedge clk) begin
        if (push_ok && !flush_i) begin
            mem[wr_ptr] <= entry_i;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_next(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R9: the producer must drop, not push, when the queue is full.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && full_o && !pop_i));

    // R8: a pop on an empty queue leaves it empty.
    p_pop_empty_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !push_i && !flush_i) |=> empty_o);

endmodule

// File: rtl/serial_rx_status.sv
// Top of the serial receiver. Connects the framer to the receive queue,
// decodes host commands, keeps the sticky overrun and change-of-break
// flags, and assembles the status word from the queue head.
// Assumes: cmd_valid and rd_pop are single-cycle strobes from the host.
module serial_rx_status
    import uart_rx_pkg::*;
#(
    parameter int OVS        = 16,
    parameter int FIFO_DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       rxd,
    input  logic [1:0] char_len,
    input  logic [1:0] parity_mode,
    input  logic       parity_sel,
    input  logic       rd_pop,
    input  logic       cmd_valid,
    input  logic [4:0] cmd_code,
    input  logic       tx_empty,
    input  logic       tx_ready,
    output logic [7:0] status,
    output logic [7:0] rx_data,
    output logic       break_chg
);

    logic      char_done;
    rx_entry_t char_w;
    logic      brk_end;
    rx_entry_t head;
    logic      q_empty;
    logic      q_full;

    logic cmd_flush;
    logic cmd_clr_err;
    logic cmd_clr_chg;
    logic pop_take;
    logic push_req;
    logic ovr_set;
    logic brk_evt;
    logic overrun_q;
    logic chg_q;

    rx_frame_engine #(.OVS(OVS)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (baud_tick),
        .rxd_i       (rxd),
        .len_sel_i   (char_len),
        .par_mode_i  (par_mode_e'(parity_mode)),
        .par_sel_i   (parity_sel),
        .char_done_o (char_done),
        .char_o      (char_w),
        .brk_end_o   (brk_end)
    );

    rx_flag_fifo #(.DEPTH(FIFO_DEPTH)) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (cmd_flush),
        .push_i  (push_req),
        .entry_i (char_w),
        .pop_i   (rd_pop),
        .head_o  (head),
        .empty_o (q_empty),
        .full_o  (q_full)
    );

    // Command decode and the push/drop decision for a completed character.
    always_comb begin
        cmd_flush   = cmd_valid && (cmd_code == CMD_FLUSH_RX);
        cmd_clr_err = cmd_valid && (cmd_code == CMD_CLR_ERR);
        cmd_clr_chg = cmd_valid && (cmd_code == CMD_CLR_BRKCHG);
        pop_take    = rd_pop && !q_empty;
        push_req    = char_done && !cmd_flush && (!q_full || pop_take);
        ovr_set     = char_done && !cmd_flush && q_full && !pop_take;
        brk_evt     = (char_done && char_w.brk) || brk_end;
    end

    // Sticky overrun flag; a new overrun wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun_q <= 1'b0;
        end else if (ovr_set) begin
            overrun_q <= 1'b1;
        end else if (cmd_clr_err) begin
            overrun_q <= 1'b0;
        end
    end

    // Change-of-break flag, raised at both ends of a break.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chg_q <= 1'b0;
        end else if (brk_evt) begin
            chg_q <= 1'b1;
        end else if (cmd_clr_chg) begin
            chg_q <= 1'b0;
        end
    end

    // Status word from the queue head and the sticky flags.
    always_comb begin
        status[7] = head.brk && !q_empty;
        status[6] = head.fe  && !q_empty;
        status[5] = head.pe  && !q_empty;
        status[4] = overrun_q;
        status[3] = tx_empty;
        status[2] = tx_ready;
        status[1] = q_full;
        status[0] = !q_empty;
        rx_data   = head.data;
        break_chg = chg_q;
    end

    // R9: overrun holds until its clear command.
    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_q && !cmd_clr_err) |=> overrun_q);

    // R6: the change flag rises only after a break start or end.
    p_chg_has_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_q) |-> $past(brk_evt));

    // R8: a full queue is never reported as empty.
    p_full_implies_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] |-> status[0]);

endmodule

// File: tb/tb_serial_rx_status.sv
module tb_serial_rx_status;

    localparam int CLK_PERIOD = 10;
    localparam int TPB        = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] char_len = 2'b11;
    logic [1:0] parity_mode = 2'b00;
    logic       parity_sel = 1'b0;
    logic       rd_pop = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [4:0] cmd_code = 5'b0;
    logic       tx_empty = 1'b1;
    logic       tx_ready = 1'b1;
    logic [7:0] status;
    logic [7:0] rx_data;
    logic       break_chg;

    serial_rx_status dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
        .char_len(char_len), .parity_mode(parity_mode), .parity_sel(parity_sel),
        .rd_pop(rd_pop), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .tx_empty(tx_empty), .tx_ready(tx_ready),
        .status(status), .rx_data(rx_data), .break_chg(break_chg)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Oversampling tick on every second clock.
    always @(posedge clk) baud_tick <= !baud_tick;

    // Behavioural reference: queue of expected entries plus sticky flags.
    typedef struct {
        logic [7:0] d;
        bit         b;
        bit         f;
        bit         p;
    } ent_t;

    ent_t mq[$];
    bit   m_over = 0;
    bit   m_chg  = 0;
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   finished = 0;

    function automatic ent_t mk(input logic [7:0] d, input bit b, input bit f, input bit p);
        ent_t e;
        e.d = d; e.b = b; e.f = f; e.p = p;
        return e;
    endfunction

    function automatic void m_push(input ent_t e);
        if (mq.size() == 8) m_over = 1;
        else mq.push_back(e);
    endfunction

    task automatic cmp(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic check(input string req);
        logic [7:0] es;
        bit ne;
        ne = (mq.size() > 0);
        es[7] = ne ? mq[0].b : 1'b0;
        es[6] = ne ? mq[0].f : 1'b0;
        es[5] = ne ? mq[0].p : 1'b0;
        es[4] = m_over;
        es[3] = tx_empty;
        es[2] = tx_ready;
        es[1] = (mq.size() == 8);
        es[0] = ne;
        cmp(req, "status", status, es);
        cmp(req, "break_chg", {7'b0, break_chg}, {7'b0, m_chg});
        if (ne) cmp(req, "rx_data", rx_data, mq[0].d);
    endtask

    task automatic hold(input logic v, input int ticks);
        rxd = v;
        repeat (ticks * 2) @(negedge clk);
    endtask

    // pbit < 0 means no parity bit on the line.
    task automatic send_frame(input logic [7:0] d, input int nb, input int pbit, input bit stop_ok);
        hold(1'b0, TPB);
        for (int i = 0; i < nb; i++) hold(d[i], TPB);
        if (pbit >= 0) hold(pbit[0], TPB);
        if (stop_ok) hold(1'b1, TPB + 4);
        else begin
            hold(1'b0, 10);
            hold(1'b1, 30);
        end
    endtask

    task automatic pop_one();
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        if (mq.size() > 0) void'(mq.pop_front());
        @(negedge clk);
    endtask

    task automatic command(input logic [4:0] c);
        cmd_valid = 1'b1;
        cmd_code  = c;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (c == 5'b00010) mq.delete();
        if (c == 5'b00100) m_over = 0;
        if (c == 5'b00101) m_chg = 0;
        @(negedge clk);
    endtask

    task automatic set_cfg(input int nb, input logic [1:0] pm, input logic ps);
        char_len    = 2'(nb - 5);
        parity_mode = pm;
        parity_sel  = ps;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R8 R10: reset state with both passthrough inputs high
        check("R8_reset");
        tx_empty = 1'b0;
        @(negedge clk);
        check("R10_passthrough");
        tx_empty = 1'b1;
        tx_ready = 1'b0;
        @(negedge clk);
        check("R10_passthrough");
        tx_ready = 1'b1;

        // R1: 8-bit characters, LSB first
        set_cfg(8, 2'b00, 1'b0);
        send_frame(8'hA5, 8, -1, 1);
        m_push(mk(8'hA5, 0, 0, 0));
        check("R1_8bit");
        send_frame(8'h3C, 8, -1, 1);
        m_push(mk(8'h3C, 0, 0, 0));
        check("R1_second");
        pop_one();
        check("R8_pop");
        pop_one();
        check("R8_pop");
        pop_one();
        check("R8_pop_empty");

        // R1: short character lengths
        set_cfg(5, 2'b00, 1'b0);
        send_frame(8'h15, 5, -1, 1);
        m_push(mk(8'h15, 0, 0, 0));
        check("R1_5bit");
        pop_one();
        set_cfg(7, 2'b00, 1'b0);
        send_frame(8'h5B, 7, -1, 1);
        m_push(mk(8'h5B, 0, 0, 0));
        check("R1_7bit");
        pop_one();

        // R1: short low glitch is not a start bit
        set_cfg(8, 2'b00, 1'b0);
        hold(1'b0, 4);
        hold(1'b1, 40);
        check("R1_glitch");

        // R2: stop sample low
        send_frame(8'h81, 8, -1, 0);
        m_push(mk(8'h81, 0, 1, 0));
        check("R2_framing");
        pop_one();

        // R3: parity modes
        set_cfg(8, 2'b01, 1'b0);
        send_frame(8'h07, 8, 1, 1);          // even, correct bit
        m_push(mk(8'h07, 0, 0, 0));
        check("R3_even_ok");
        pop_one();
        send_frame(8'h07, 8, 0, 1);          // even, wrong bit
        m_push(mk(8'h07, 0, 0, 1));
        check("R3_even_bad");
        pop_one();
        set_cfg(8, 2'b01, 1'b1);
        send_frame(8'h03, 8, 1, 1);          // odd, correct bit
        m_push(mk(8'h03, 0, 0, 0));
        check("R3_odd_ok");
        pop_one();
        set_cfg(6, 2'b10, 1'b1);
        send_frame(8'h2A, 6, 0, 1);          // forced 1, received 0
        m_push(mk(8'h2A, 0, 0, 1));
        check("R3_force_bad");
        pop_one();
        send_frame(8'h2A, 6, 1, 1);          // forced 1, received 1
        m_push(mk(8'h2A, 0, 0, 0));
        check("R3_force_ok");
        pop_one();
        set_cfg(8, 2'b11, 1'b0);
        send_frame(8'h40, 8, 1, 1);          // address marker stored
        m_push(mk(8'h40, 0, 0, 1));
        check("R3_addr_bit");
        pop_one();

        // R4 R5 R6: long break gives one entry and flags both edges
        set_cfg(8, 2'b00, 1'b0);
        hold(1'b0, TPB * 40);
        m_push(mk(8'h00, 1, 0, 0));
        m_chg = 1;
        check("R4_break_entry");
        command(5'b00101);
        check("R6_clear");
        hold(1'b1, 4);
        hold(1'b0, 30);
        check("R5_short_mark");
        hold(1'b1, 20);
        m_chg = 1;
        check("R6_break_end");
        send_frame(8'h5A, 8, -1, 1);
        m_push(mk(8'h5A, 0, 0, 0));
        check("R5_resume");
        pop_one();
        check("R5_resume");
        pop_one();
        command(5'b00101);

        // R7: break beginning inside a character
        hold(1'b0, TPB);
        for (int i = 0; i < 3; i++) hold(1'b1, TPB);
        hold(1'b0, TPB * 30);
        m_push(mk(8'h07, 0, 1, 0));
        m_push(mk(8'h00, 1, 0, 0));
        m_chg = 1;
        check("R7_damaged_char");
        hold(1'b1, 20);
        pop_one();
        check("R7_break_next");
        pop_one();
        command(5'b00101);

        // R11 R9: flush, then overflow the queue
        send_frame(8'h11, 8, -1, 1);
        m_push(mk(8'h11, 0, 0, 0));
        command(5'b00010);
        check("R11_flush");
        for (int i = 0; i < 9; i++) begin
            send_frame(8'(8'h20 + i), 8, -1, 1);
            m_push(mk(8'(8'h20 + i), 0, 0, 0));
        end
        check("R9_overrun");
        command(5'b00011);
        check("R11_other_code");
        command(5'b00100);
        check("R9_clear");
        for (int i = 0; i < 8; i++) begin
            pop_one();
            check("R8_drain");
        end
        pop_one();
        check("R8_pop_empty");

        finish_run();
    end

endmodule